// File: doc/BRIEF.md
# Interrupt Mask and End-of-Interrupt Front-End

This block sits between up to 64 peripheral interrupt sources and a parent interrupt controller. Each source has its own output line to the parent: output `n` feeds the parent input at a fixed base plus `n`, so the line order is preserved. A mask bit per line holds the line back, and 1 means masked. Each line is built either as a level line or as an edge line. A level line passes its input straight through the mask. An edge line catches a rising input edge in a pending latch, and software retires the latch with an end-of-interrupt (EOI) write.

Software reaches the block over a small single-cycle register port. Each register is 16 bits wide, and the registers sit on a 4-byte stride. There are two banks: a mask bank that reads back its current value, so software can do read-modify-write, and an EOI bank that is write-only. A build parameter removes the EOI logic. In that build every line behaves as a level line, and writes to the EOI bank are accepted and discarded.

Top module: `irq_mask_eoi`

## Requirements
- R1: After reset every existing line is masked, every pending latch is clear, every output is 0, and each mask register reads back 1s for the lines it holds.
- R2: Line n is bit (n mod 16) of the register at bank base + 4*(n/16); the mask bank base is byte offset 0x00 and the EOI bank base is 0x20.
- R3: A write to a mask register replaces all 16 bits; a later read returns the written value, with bits of lines at or above NUM_LINES reading 0.
- R4: A mask bit of 1 forces the line's output to 0; a mask bit of 0 lets the line drive its output.
- R5: A level line's output equals its input AND NOT its mask bit, in the same cycle, with no register on the path.
- R6: On an edge line, a clock-sampled 0-to-1 input change sets the pending latch even while the line is masked. The output is pending AND NOT mask, and it stays high after the input falls.
- R7: Writing 1 to an edge line's EOI bit clears its pending latch at that clock edge, and 0 bits change nothing. A rising edge in the same cycle as the EOI write wins, so the latch stays set. EOI registers always read 0.
- R8: An EOI write to a level line has no effect on its output.
- R9: A misaligned byte address (low two bits non-zero), or an offset in 0x10-0x1F or 0x30-0x3F, reads 0 and ignores writes.
- R10: With HAS_EOI = 0 every line behaves as a level line and EOI-bank writes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| regWe | input | 1 | Register write enable |
| regAddr | input | 6 | Byte address inside the register window |
| regWdata | input | 16 | Write data |
| regRdata | output | 16 | Read data for regAddr (combinational) |
| irqIn | input | NUM_LINES | Interrupt source inputs |
| irqOut | output | NUM_LINES | Per-line outputs to the parent controller |

## Verification
The bench aims at the EOI write that arrives in the same cycle as a new rising edge. A design that lets the clear win drops that interrupt for good. It also checks that an edge line latches while masked, so that unmasking later shows the interrupt: a design that gates the latch with the mask would lose it. The bench writes EOI to level lines and to the build without EOI, and it writes to misaligned and out-of-window addresses. A decoder that is too loose would then disturb mask bits, or read back non-zero data. A second build with 40 lines shows whether the bits of missing lines leak into the readback.

// File: rtl/irq_fe_pkg.sv
package irq_fe_pkg;
  localparam int MAX_LINES = 64;
  localparam int REG_W     = 16;
  localparam int MAX_REGS  = MAX_LINES / REG_W;
  localparam int IDX_W     = $clog2(MAX_REGS);
  localparam int ADDR_W    = 6;

  // bank selector held in regAddr[5:4]
  localparam logic [1:0] BANK_MASK = 2'b00;
  localparam logic [1:0] BANK_EOI  = 2'b10;

  typedef struct packed {
    logic [MAX_REGS-1:0] maskWr;   // one-hot mask register write
    logic [MAX_REGS-1:0] eoiWr;    // one-hot EOI register write
    logic                rdHit;    // read targets a mask register
    logic [IDX_W-1:0]    rdIdx;    // which mask register
    logic [REG_W-1:0]    data;     // write data
  } strobe_t;

  function automatic logic [MAX_LINES-1:0] validBits(input int n);
    logic [MAX_LINES-1:0] v;
    for (int i = 0; i < MAX_LINES; i++) v[i] = (i < n);
    return v;
  endfunction
endpackage

// File: rtl/irq_fe_ctrl.sv
module irq_fe_ctrl
  import irq_fe_pkg::*;
#(
  parameter bit HAS_EOI = 1'b1
) (
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWdata,
  output strobe_t           stb
);
  logic              aligned;
  logic [1:0]        bank;
  logic [IDX_W-1:0]  idx;
  logic [MAX_REGS-1:0] idxOneHot;
  logic              maskHit;
  logic              eoiHit;

  assign aligned   = (regAddr[1:0] == 2'b00);
  assign bank      = regAddr[5:4];
  assign idx       = regAddr[3:2];
  assign idxOneHot = MAX_REGS'(1) << idx;
  assign maskHit   = aligned && (bank == BANK_MASK);
  assign eoiHit    = aligned && (bank == BANK_EOI);

  always_comb begin
    stb.maskWr = (regWe && maskHit) ? idxOneHot : '0;
    stb.rdHit  = maskHit;
    stb.rdIdx  = idx;
    stb.data   = regWdata;
  end

  if (HAS_EOI) begin : g_eoi
    always_comb stb.eoiWr = (regWe && eoiHit) ? idxOneHot : '0;
  end else begin : g_no_eoi
    logic unusedEoi;
    assign unusedEoi = eoiHit;
    always_comb stb.eoiWr = '0;
  end
endmodule

// File: rtl/irq_fe_datapath.sv
module irq_fe_datapath
  import irq_fe_pkg::*;
#(
  parameter int                   NUM_LINES  = 64,
  parameter bit                   HAS_EOI    = 1'b1,
  parameter logic [MAX_LINES-1:0] EDGE_LINES = 64'hFFFF_FFFF_0000_0000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  strobe_t              stb,
  input  logic [NUM_LINES-1:0] irqIn,
  output logic [NUM_LINES-1:0] irqOut,
  output logic [REG_W-1:0]     rdata
);
  localparam logic [MAX_LINES-1:0] VALID    = validBits(NUM_LINES);
  localparam logic [MAX_LINES-1:0] EDGE_EFF = HAS_EOI ? (EDGE_LINES & VALID) : '0;

  logic [REG_W-1:0] maskQ [MAX_REGS];

  for (genvar r = 0; r < MAX_REGS; r++) begin : g_mask
    always_ff @(posedge clk) begin
      if (rst)
        maskQ[r] <= VALID[r*REG_W +: REG_W];
      else if (stb.maskWr[r])
        maskQ[r] <= stb.data & VALID[r*REG_W +: REG_W];
    end
  end

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    localparam int R = n / REG_W;
    localparam int B = n % REG_W;
    if (EDGE_EFF[n]) begin : g_edge
      logic prevQ;
      logic pendQ;
      logic riseD;
      logic clrD;
      assign riseD = irqIn[n] && !prevQ;
      assign clrD  = stb.eoiWr[R] && stb.data[B];
      always_ff @(posedge clk) begin
        if (rst) begin
          prevQ <= 1'b0;
          pendQ <= 1'b0;
        end else begin
          prevQ <= irqIn[n];
          pendQ <= riseD || (pendQ && !clrD);   // new edge beats EOI
        end
      end
      assign irqOut[n] = pendQ && !maskQ[R][B];
    end else begin : g_level
      assign irqOut[n] = irqIn[n] && !maskQ[R][B];
    end
  end

  assign rdata = stb.rdHit ? maskQ[stb.rdIdx] : '0;
endmodule

// File: rtl/irq_mask_eoi.sv
module irq_mask_eoi
  import irq_fe_pkg::*;
#(
  parameter int                   NUM_LINES  = 64,
  parameter bit                   HAS_EOI    = 1'b1,
  parameter logic [MAX_LINES-1:0] EDGE_LINES = 64'hFFFF_FFFF_0000_0000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 regWe,
  input  logic [5:0]           regAddr,
  input  logic [15:0]          regWdata,
  output logic [15:0]          regRdata,
  input  logic [NUM_LINES-1:0] irqIn,
  output logic [NUM_LINES-1:0] irqOut
);
  strobe_t stb;

  irq_fe_ctrl #(.HAS_EOI(HAS_EOI)) u_ctrl (
    .regWe   (regWe),
    .regAddr (regAddr),
    .regWdata(regWdata),
    .stb     (stb)
  );

  irq_fe_datapath #(
    .NUM_LINES (NUM_LINES),
    .HAS_EOI   (HAS_EOI),
    .EDGE_LINES(EDGE_LINES)
  ) u_dp (
    .clk   (clk),
    .rst   (rst),
    .stb   (stb),
    .irqIn (irqIn),
    .irqOut(irqOut),
    .rdata (regRdata)
  );
endmodule

// File: rtl/irq_fe_checker.sv
module irq_fe_checker
  import irq_fe_pkg::*;
#(
  parameter int                   NUM_LINES  = 64,
  parameter bit                   HAS_EOI    = 1'b1,
  parameter logic [MAX_LINES-1:0] EDGE_LINES = 64'hFFFF_FFFF_0000_0000
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 regWe,
  input logic [5:0]           regAddr,
  input logic [15:0]          regWdata,
  input logic [15:0]          regRdata,
  input logic [NUM_LINES-1:0] irqIn,
  input logic [NUM_LINES-1:0] irqOut
);
  localparam logic [MAX_LINES-1:0] VALID    = validBits(NUM_LINES);
  localparam logic [MAX_LINES-1:0] EDGE_EFF = HAS_EOI ? (EDGE_LINES & VALID) : '0;
  localparam logic [NUM_LINES-1:0] LEVEL_M  = ~EDGE_EFF[NUM_LINES-1:0];
  localparam logic [15:0]          VALID0   = VALID[15:0];

  AST_RESET_ALL_MASKED: assert property (@(posedge clk)
    $fell(rst) |-> (irqOut == '0)) else $error("R1 outputs active after reset"); // R1

  AST_RESET_MASK_READ: assert property (@(posedge clk)
    ($fell(rst) && regAddr == 6'h00) |-> (regRdata == VALID0)) else $error("R1 mask reset value"); // R1

  AST_MASK_READBACK: assert property (@(posedge clk) disable iff (rst)
    (regAddr == 6'h00 && !$past(rst) && $past(regWe) && $past(regAddr) == 6'h00)
      |-> (regRdata == ($past(regWdata) & VALID0))) else $error("R3 readback"); // R3

  AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    ((irqOut & ~irqIn & LEVEL_M) == '0)) else $error("R5 level output without input"); // R5

  AST_EOI_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (regAddr[5:4] == BANK_EOI) |-> (regRdata == '0)) else $error("R7 EOI read non-zero"); // R7

  AST_OUTSIDE_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (regAddr[1:0] != 2'b00 || regAddr[4]) |-> (regRdata == '0)) else $error("R9 outside read"); // R9

  if (!HAS_EOI) begin : g_no_eoi_chk
    AST_NO_EOI_LEVEL: assert property (@(posedge clk) disable iff (rst)
      ((irqOut & ~irqIn) == '0)) else $error("R10 output without input"); // R10
  end

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_edge_chk
    if (EDGE_EFF[n]) begin : g_e
      AST_EDGE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (irqOut[n] && !regWe) |=> irqOut[n]) else $error("R6 edge output dropped"); // R6
    end
  end
endmodule

bind irq_mask_eoi irq_fe_checker #(
  .NUM_LINES (NUM_LINES),
  .HAS_EOI   (HAS_EOI),
  .EDGE_LINES(EDGE_LINES)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .regWe   (regWe),
  .regAddr (regAddr),
  .regWdata(regWdata),
  .regRdata(regRdata),
  .irqIn   (irqIn),
  .irqOut  (irqOut)
);

// File: tb/test_irq_mask_eoi.sv
module test_irq_mask_eoi;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] EDGE1   = 64'hFFFF_FFFF_0000_0000;
  localparam int          LINES2  = 40;
  localparam logic [63:0] VALID2  = (64'd1 << LINES2) - 64'd1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic regWe = 1'b0;
  logic [5:0] regAddr = '0;
  logic [15:0] regWdata = '0;
  logic [63:0] irqIn1 = '0;
  logic [LINES2-1:0] irqIn2 = '0;
  logic [15:0] rd1, rd2;
  logic [63:0] irqOut1;
  logic [LINES2-1:0] irqOut2;

  int checks = 0;
  int fails  = 0;

  logic [63:0] m1, p1, prev1, m2;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_mask_eoi #(.NUM_LINES(64), .HAS_EOI(1'b1), .EDGE_LINES(EDGE1)) i_irq_mask_eoi (
    .clk(clk), .rst(rst), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(rd1), .irqIn(irqIn1), .irqOut(irqOut1));

  irq_mask_eoi #(.NUM_LINES(LINES2), .HAS_EOI(1'b0), .EDGE_LINES(EDGE1)) i_irq_mask_eoi_noeoi (
    .clk(clk), .rst(rst), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(rd2), .irqIn(irqIn2), .irqOut(irqOut2));

  function automatic logic [15:0] expRead(logic [63:0] m, logic [5:0] a);
    if (a[1:0] == 2'b00 && a[5:4] == 2'b00) return m[a[3:2]*16 +: 16];
    return 16'h0;
  endfunction

  function automatic logic [63:0] expOut1(logic [63:0] inV);
    return ~m1 & ((EDGE1 & p1) | (~EDGE1 & inV));
  endfunction

  function automatic logic [63:0] expOut2(logic [63:0] inV);
    return ~m2 & inV & VALID2;
  endfunction

  task automatic chk(string tag, string what, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
    end
  endtask

  task automatic resetModel();
    m1 = '1; p1 = '0; prev1 = '0; m2 = VALID2;
  endtask

  task automatic step(string tag, logic we, logic [5:0] a, logic [15:0] d, logic [63:0] inV);
    logic [63:0] clr;
    @(negedge clk);
    regWe = we; regAddr = a; regWdata = d; irqIn1 = inV; irqIn2 = inV[LINES2-1:0];
    #1;
    chk(tag, "irqOut full", irqOut1, expOut1(inV));
    chk(tag, "rdata full", {48'h0, rd1}, {48'h0, expRead(m1, a)});
    chk(tag, "irqOut no-eoi", {24'h0, irqOut2}, expOut2(inV));
    chk(tag, "rdata no-eoi", {48'h0, rd2}, {48'h0, expRead(m2, a)});
    @(posedge clk);
    clr = '0;
    if (we && a[1:0] == 2'b00 && a[5:4] == 2'b00) begin
      m1[a[3:2]*16 +: 16] = d;
      m2[a[3:2]*16 +: 16] = d & VALID2[a[3:2]*16 +: 16];
    end
    if (we && a[1:0] == 2'b00 && a[5:4] == 2'b10) clr[a[3:2]*16 +: 16] = d;
    p1 = ((p1 & ~clr) | (inV & ~prev1)) & EDGE1;
    prev1 = inV;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] cur;
    void'($urandom(32'd4242));
    resetModel();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1: reset state, all inputs high but masked
    cur = '1;
    step("R1", 0, 6'h00, 0, cur);
    step("R1", 0, 6'h04, 0, cur);
    step("R1", 0, 6'h08, 0, cur);
    step("R1", 0, 6'h0C, 0, cur);

    // R2: unmask only line 17 (bit 1 of the register at 0x04)
    step("R2", 1, 6'h04, 16'hFFFD, cur);
    step("R2", 0, 6'h04, 0, cur);
    step("R2", 1, 6'h04, 16'hFFFF, cur);

    // R4: unmask then re-mask lines 0..15
    step("R4", 1, 6'h00, 16'h0000, cur);
    step("R4", 0, 6'h00, 0, cur);
    step("R4", 1, 6'h00, 16'hFFFF, cur);
    step("R4", 1, 6'h00, 16'h0000, cur);

    // R5: level lines follow input the same cycle
    cur[15:0] = 16'h0000;
    step("R5", 0, 6'h00, 0, cur);
    cur[15:0] = 16'hA5A5;
    step("R5", 0, 6'h00, 0, cur);
    cur[15:0] = 16'hFFFF;

    // R6: lines 32..47 latched while masked, appear on unmask, hold after input falls
    step("R6", 1, 6'h08, 16'h0000, cur);
    step("R6", 0, 6'h08, 0, cur);
    cur[47:32] = 16'h0000;
    step("R6", 0, 6'h08, 0, cur);
    step("R6", 0, 6'h08, 0, cur);

    // R7: EOI zero bits do nothing, one bit clears, simultaneous edge wins, reads 0
    step("R7", 1, 6'h28, 16'h0000, cur);
    step("R7", 1, 6'h28, 16'h0001, cur);
    step("R7", 0, 6'h28, 0, cur);
    cur[33] = 1'b1;
    step("R7", 1, 6'h28, 16'h0002, cur);
    step("R7", 0, 6'h2C, 0, cur);

    // R8: EOI to level lines 0..15 leaves outputs unchanged
    step("R8", 1, 6'h20, 16'hFFFF, cur);
    step("R8", 0, 6'h00, 0, cur);

    // R9: out-of-window and misaligned accesses
    step("R9", 1, 6'h01, 16'h1234, cur);
    step("R9", 1, 6'h10, 16'h0000, cur);
    step("R9", 1, 6'h30, 16'h0000, cur);
    step("R9", 1, 6'h3C, 16'h0000, cur);
    step("R9", 1, 6'h22, 16'hFFFF, cur);
    step("R9", 0, 6'h14, 0, cur);
    step("R9", 0, 6'h0A, 0, cur);
    step("R9", 0, 6'h00, 0, cur);

    // R10: no-EOI build, edge-flagged lines 32..39 act as level
    step("R10", 1, 6'h08, 16'h0000, cur);
    cur[39:32] = 8'h00;
    step("R10", 1, 6'h28, 16'hFFFF, cur);
    cur[39:32] = 8'h5A;
    step("R10", 0, 6'h08, 0, cur);

    // R3: constrained random mix of reads, writes and input activity
    for (int i = 0; i < 4000; i++) begin
      logic [5:0] a;
      logic we;
      if ($urandom % 4 != 0) a = {($urandom % 2) ? 2'b10 : 2'b00, 2'($urandom), 2'b00};
      else a = 6'($urandom);
      we = ($urandom % 3 == 0);
      cur = cur ^ ({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
      step("R3", we, a, 16'($urandom), cur);
    end

    // R1: reset again in mid-run
    @(negedge clk); rst = 1'b1;
    @(posedge clk); @(negedge clk);
    irqIn1 = '0; irqIn2 = '0; resetModel();
    @(posedge clk); @(negedge clk); rst = 1'b0;
    step("R1", 0, 6'h00, 0, '0);
    step("R1", 0, 6'h08, 0, '0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule